// File: doc/BRIEF.md
# Vectored Interrupt Sequencer

This block is the interrupt front end of a small pipelined microcontroller core. It keeps one sticky flag per interrupt source: an asynchronous external pin, a timer event and a group of eight peripheral events. Each flag passes through its own enable. The peripheral flags also pass through a group enable. Every path then passes through one global enable. A flag records its event whatever the enables hold, so software can poll sources that are masked.

When an enabled flag is pending and the global enable is set, the sequencer takes over the core for a fixed redirect. In the first instruction cycle it flushes the prefetched instruction, clears the global enable, pushes the core's current program counter onto an eight-entry return stack and loads the vector address 0x0004. It then holds the core for two dummy execute cycles, and the instruction at the vector executes after them. A return request from the core pops the saved address into the program counter and sets the global enable again in one step. All sequencing advances on a cycle-phase strobe that marks instruction-cycle boundaries. Flag capture and register writes take effect on any clock edge.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, the global enable, the group enable, all individual enables and all flags are 0, every register reads 0, and flush, pc_load and dummy are low.
- R2: A redirect is taken only when the global enable is set and at least one source is enabled. The external source needs ctrl bit 4 and flag bit 1. The timer needs ctrl bit 5 and flag bit 2. Peripheral source k needs group enable ctrl bit 6, mask bit k and peripheral flag bit k.
- R3: Each flag sets on its event whatever the enables hold. An event wins over a software write of 0 to its flag on the same clock edge.
- R4: On the strobe edge that accepts an interrupt, flush and pc_load go high, pc_next becomes 0x0004, the global enable reads 0, and pc_in is pushed onto the return stack.
- R5: While the global enable is clear, a pending enabled flag causes no redirect. It is taken on the strobe edge after software sets the global enable.
- R6: A return request on a strobe edge while no redirect is running does three things on that edge: it loads pc_next with the most recently pushed address, raises pc_load and sets the global enable.
- R7: Flags are not cleared on entry. A flag still set when the handler returns causes another redirect on the next strobe edge.
- R8: With the strobe high every clock, a synchronous event sampled on edge E0 gives flush on E1, dummy high after E1 and after E2, and dummy low after E3: a latency of 3 instruction cycles. The external pin adds one cycle, for 4. With a slower strobe, the latency counted in strobe edges is still 3. No new redirect starts during the dummy cycles.
- R9: Register map:
  - Address 0 is the control register: bit 7 global enable, bit 6 group enable, bit 5 timer enable, bit 4 external enable, bit 2 timer flag, bit 1 external flag. Bits 3 and 0 read 0.
  - Address 1 holds the peripheral flags.
  - Address 2 holds the peripheral masks.
  - Address 3 reads 0.
- R10: The return stack is last-in first-out with eight entries. A ninth push wraps around and overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_q1 | input | 1 | Instruction-cycle boundary strobe; sequencing advances only on edges where it is high |
| ext_pin | input | 1 | Asynchronous external interrupt pin, rising edge sensitive |
| tmr_evt | input | 1 | Synchronous timer event pulse |
| periph_evt | input | 8 | Synchronous peripheral event pulses |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pc_in | input | PC_W | Core program counter to save on entry |
| ret_req | input | 1 | Return-from-interrupt request from the core |
| flush | output | 1 | Discard the prefetched instruction |
| pc_load | output | 1 | Load pc_next into the core program counter |
| pc_next | output | PC_W | Vector or return address |
| dummy | output | 1 | Current execute slot is a dummy cycle |

## Verification
The assertions assume two things about the core. It raises ret_req only between redirects, on a strobe edge. It keeps pc_in stable across the accepting edge. They also assume that software does not write the control register on the accepting edge. The stimulus respects all three. Every input changes on the falling clock edge. Returns are issued only after the dummy cycles have ended. Register writes are spaced so that none lands on an accept or return edge. Random trials draw the enable states and the source from a fixed seed, and every trial starts from flags cleared by software.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int PC_W      = 13,
  parameter int STK_DEPTH = 8,
  parameter int VEC_ADDR  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_q1,
  input  logic            ext_pin,
  input  logic            tmr_evt,
  input  logic [7:0]      periph_evt,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [PC_W-1:0] pc_in,
  input  logic            ret_req,
  output logic            flush,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic            dummy
);
  localparam int SP_W = $clog2(STK_DEPTH);
  localparam logic [PC_W-1:0] VECTOR = PC_W'(VEC_ADDR);

  typedef enum logic [1:0] {S_IDLE, S_D1, S_D2} seq_t;
  seq_t st;

  logic gie, peie, tmr_en, ext_en, tmr_f, ext_f;
  logic [7:0] pflag, pen;
  logic ext_s1, ext_s2;
  logic [PC_W-1:0] stk [STK_DEPTH];
  logic [SP_W-1:0] sp;

  wire ext_rise = ext_s1 & ~ext_s2;
  wire wr_ctrl  = reg_we && reg_addr == 2'd0;
  wire wr_pflag = reg_we && reg_addr == 2'd1;
  wire wr_pen   = reg_we && reg_addr == 2'd2;

  wire src_hit = (ext_en & ext_f) | (tmr_en & tmr_f) | (peie & |(pflag & pen));
  wire idle_q1 = cyc_q1 && st == S_IDLE;
  wire do_ret  = idle_q1 && ret_req;
  wire accept  = idle_q1 && !ret_req && gie && src_hit;
  wire [SP_W-1:0] sp_top = sp - SP_W'(1);

  assign dummy = st != S_IDLE;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {gie, peie, tmr_en, ext_en, 1'b0, tmr_f, ext_f, 1'b0};
      2'd1:    reg_rdata = pflag;
      2'd2:    reg_rdata = pen;
      default: reg_rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
    end else begin
      ext_s1 <= ext_pin;
      ext_s2 <= ext_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {gie, peie, tmr_en, ext_en, tmr_f, ext_f} <= '0;
      pflag <= '0;
      pen   <= '0;
    end else begin
      if (wr_ctrl) {gie, peie, tmr_en, ext_en} <= reg_wdata[7:4];
      if (accept) gie <= 1'b0;
      else if (do_ret) gie <= 1'b1;
      tmr_f <= (wr_ctrl ? reg_wdata[2] : tmr_f) | tmr_evt;
      ext_f <= (wr_ctrl ? reg_wdata[1] : ext_f) | ext_rise;
      pflag <= (wr_pflag ? reg_wdata : pflag) | periph_evt;
      if (wr_pen) pen <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      flush   <= 1'b0;
      pc_load <= 1'b0;
      pc_next <= '0;
      sp      <= '0;
    end else if (cyc_q1) begin
      flush   <= accept;
      pc_load <= accept | do_ret;
      if (accept) begin
        pc_next <= VECTOR;
        sp      <= sp + SP_W'(1);
      end else if (do_ret) begin
        pc_next <= stk[sp_top];
        sp      <= sp_top;
      end
      case (st)
        S_IDLE:  st <= accept ? S_D1 : S_IDLE;
        S_D1:    st <= S_D2;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (accept) stk[sp] <= pc_in;

  AST_ENTRY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flush && pc_load && pc_next == VECTOR && !gie) else $error("entry"); // R4
  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> gie && pc_load && !flush) else $error("return"); // R6
  AST_TWO_DUMMIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q1 && st == S_D1) |=> st == S_D2 && dummy) else $error("dummy"); // R8
  AST_NO_NESTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q1 && st != S_IDLE) |=> !pc_load) else $error("nest"); // R8
  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_evt) |=> (pflag & $past(periph_evt)) == $past(periph_evt)) else $error("flag"); // R3
  AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q1 && !gie) |=> !flush) else $error("masked"); // R5
endmodule

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;
  localparam int CLK_P = 10;
  localparam int PC_W  = 13;

  logic clk = 1'b0, rst_n = 1'b0, cyc_q1 = 1'b1;
  logic ext_pin = 1'b0, tmr_evt = 1'b0, reg_we = 1'b0, ret_req = 1'b0;
  logic [7:0] periph_evt = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  logic [PC_W-1:0] pc_in = '0, pc_next;
  logic flush, pc_load, dummy;
  int checks = 0, fails = 0;
  logic [PC_W-1:0] mstk [8];
  int msp = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_sequencer #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_q1(cyc_q1), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
    .periph_evt(periph_evt), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pc_in(pc_in), .ret_req(ret_req), .flush(flush),
    .pc_load(pc_load), .pc_next(pc_next), .dummy(dummy));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic bit exp_take(logic [7:0] ctrl, logic [7:0] pen, int src, int k);
    if (!ctrl[7]) return 1'b0;
    case (src)
      0: return ctrl[6] && pen[k];
      1: return ctrl[5];
      default: return ctrl[4];
    endcase
  endfunction

  task automatic push_model(logic [PC_W-1:0] v);
    mstk[msp] = v; msp = (msp + 1) % 8;
  endtask

  task automatic ret_and_check(string tag);
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
    msp = (msp + 7) % 8;
    chk({tag, " pc_load on return"}, int'(pc_load), 1);
    chk({tag, " popped address"}, int'(pc_next), int'(mstk[msp]));
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1DEA5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register after reset", int'(d), 0);
    end
    chk("R1 outputs idle", int'({flush, pc_load, dummy}), 0);

    // R9 register map
    wr(0, 8'h7F); rd(0, d); chk("R9 ctrl readback", int'(d), 'h76);
    wr(1, 8'hA5); rd(1, d); chk("R9 flag readback", int'(d), 'hA5);
    wr(2, 8'h3C); rd(2, d); chk("R9 mask readback", int'(d), 'h3C);
    rd(3, d); chk("R9 unused address", int'(d), 0);
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);

    // R3 event beats same-edge software clear
    wr(1, 8'h10);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00; periph_evt = 8'h04;
    step();
    reg_we = 1'b0; periph_evt = '0;
    rd(1, d); chk("R3 event wins over clear", int'(d), 'h04);
    wr(1, 8'h00);

    // R5 masked pending, then enabling
    wr(0, 8'h24);
    begin
      int seen = 0;
      repeat (5) begin step(); seen += int'(pc_load); end
      chk("R5 no redirect while global enable clear", seen, 0);
    end
    pc_in = 13'h123;
    wr(0, 8'hA4);
    step();
    push_model(pc_in);
    chk("R5 taken after global enable set", int'(pc_load & flush), 1);
    chk("R4 vector address", int'(pc_next), 4);
    rd(0, d); chk("R4 global enable cleared, R7 flag kept", int'(d), 'h24);
    step(); step();
    chk("R8 dummies over", int'(dummy), 0);

    // R6 return without clearing flag, then R7 re-entry
    reg_addr = 2'd0;
    ret_and_check("R6");
    #1; chk("R6 global enable set by return", int'(reg_rdata[7]), 1);
    step();
    push_model(pc_in);
    chk("R7 uncleared flag re-taken", int'(pc_load & flush), 1);
    chk("R7 vector again", int'(pc_next), 4);
    step(); step();
    wr(0, 8'h00);
    ret_and_check("R6 second");

    // R10 nested pushes past depth, then pops
    for (int i = 0; i < 10; i++) begin
      pc_in = PC_W'(13'h100 + i * 7);
      wr(0, 8'hA4);
      step();
      chk("R10 nested entry", int'(pc_load), 1);
      push_model(pc_in);
      step(); step();
    end
    wr(0, 8'h00);
    for (int i = 0; i < 10; i++) ret_and_check("R10 pop order");

    // R8 slow strobe latency in strobe edges
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h01); wr(0, 8'hC0);
    begin
      int ticks = 0, lat = -1;
      bit seen_d = 0;
      for (int n = 0; n < 40; n++) begin
        cyc_q1 = (n % 4 == 0);
        periph_evt = (n == 0) ? 8'h01 : 8'h00;
        @(posedge clk);
        if (cyc_q1 && n > 0) ticks++;
        @(negedge clk);
        if (dummy) seen_d = 1;
        if (seen_d && !dummy && lat < 0) lat = ticks;
      end
      cyc_q1 = 1'b1; periph_evt = '0;
      chk("R8 latency with slow strobe", lat, 3);
    end

    // R2 R3 R8 random trials
    for (int t = 0; t < 60; t++) begin
      logic [7:0] ctrl, pen;
      int src, k, first, fall;
      bit take;
      wr(0, 8'h00); wr(1, 8'h00);
      ctrl = {4'($urandom), 4'h0};
      pen = 8'($urandom);
      src = $urandom % 3;
      k = $urandom % 8;
      take = exp_take(ctrl, pen, src, k);
      wr(2, pen); wr(0, ctrl);
      first = -1; fall = -1;
      case (src)
        0: periph_evt[k] = 1'b1;
        1: tmr_evt = 1'b1;
        default: ext_pin = 1'b1;
      endcase
      for (int c = 0; c < 8; c++) begin
        step();
        if (c == 0) begin periph_evt = '0; tmr_evt = 1'b0; end
        if (c == 2) ext_pin = 1'b0;
        if (pc_load && first < 0) begin
          first = c;
          chk("R4 random vector", int'(pc_next), 4);
        end
        if (first >= 0 && c > first && !dummy && fall < 0) fall = c;
      end
      if (take) begin
        chk("R2 accept edge", first, (src == 2) ? 2 : 1);
        chk("R8 latency", fall, (src == 2) ? 4 : 3);
      end else
        chk("R2 no redirect when disabled", first, -1);
      case (src)
        0: begin rd(1, d); chk("R3 peripheral flag latched", int'(d[k]), 1); end
        1: begin rd(0, d); chk("R3 timer flag latched", int'(d[2]), 1); end
        default: begin rd(0, d); chk("R3 external flag latched", int'(d[1]), 1); end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule